// File: doc/BRIEF.md
# Flag-Gated Two-Queue Instruction Dispatcher

This block sits between an instruction parser and two execution units: one that moves data between memory and local buffers, and one that computes. Decoded instructions arrive on a single stream, each tagged with its kind, and are placed in one of two eight-entry issue queues. Each queue issues strictly in arrival order, one instruction at a time, but the two queues run independently. A data-movement instruction can therefore go ahead of, or alongside, a compute instruction that is stalled.

Ordering between the queues comes only from a 16-bit register of producer/consumer flags. Every instruction carries four masks: flags that must be set before it may issue, flags that must be clear before it may issue, flags to set when it completes and flags to clear when it completes. One flag can mark that a buffer holds valid data, and the same flag can mark that a buffer is still being read. This lets a load wait for a consumer to release a buffer, and lets a compute wait for its operands to arrive. The execution units report completion with single-cycle pulses. These pulses update the flags before the issue decisions made in that same cycle.

Top module: `depflag_dispatch`

## Requirements
- R1: After reset the flag register is all zero, neither go output is asserted, and `in_ready` is high for both kinds.
- R2: `in_kind` = 0 routes an instruction to the data-movement queue and `in_kind` = 1 routes it to the compute queue. Each queue issues its instructions, shown by a one-cycle go pulse carrying the tag, in the order they were accepted.
- R3: An instruction issues only when every bit of its wait-set mask is 1 in the flag register.
- R4: An instruction issues only when every bit of its wait-clear mask is 0 in the flag register. For example, a load waits until the compute reading its buffer clears that flag.
- R5: A data-movement instruction issues while the compute queue head is blocked on its flags. A compute instruction can issue in the same cycle as a data-movement instruction.
- R6: When a completion pulse arrives for an issued instruction, the bits of its clear-on-done mask are cleared, then the bits of its set-on-done mask are set. A bit that appears in both masks ends at 1.
- R7: If both units complete in the same cycle, the data-movement update is applied first and the compute update second. On a conflicting bit, the compute result wins.
- R8: A completion in a cycle counts toward the issue checks of that same cycle. A waiting instruction's go pulse appears in the cycle right after the completion pulse.
- R9: Each kind has at most one outstanding instruction. The next instruction of that kind issues no earlier than the cycle its predecessor's completion pulse is seen, with its go pulse in the following cycle.
- R10: `in_ready` is low when the queue selected by `in_kind` holds 8 entries. An instruction presented while ready is low is dropped, and the other kind is still accepted.
- R11: A completion pulse for a unit with nothing outstanding leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present on the input |
| in_kind | input | 1 | 0 = data movement, 1 = compute |
| in_tag | input | 8 | Instruction identifier returned on issue |
| in_wait_set | input | 16 | Flags required to be 1 before issue |
| in_wait_clr | input | 16 | Flags required to be 0 before issue |
| in_set_done | input | 16 | Flags set on completion |
| in_clr_done | input | 16 | Flags cleared on completion |
| in_ready | output | 1 | Target queue has room |
| dma_go | output | 1 | One-cycle issue pulse to the data-movement unit |
| dma_go_tag | output | 8 | Tag of the issued data-movement instruction |
| cmp_go | output | 1 | One-cycle issue pulse to the compute unit |
| cmp_go_tag | output | 8 | Tag of the issued compute instruction |
| dma_done | input | 1 | Data-movement completion pulse |
| cmp_done | input | 1 | Compute completion pulse |
| flags | output | 16 | Current flag register |

## Verification
Two flag writers and the issue logic can act in the same cycle. One such case is a data-movement completion that releases a waiting compute while the next load issues. Another is both units completing together with masks that disagree on one bit. The vector table sets up both cases. The first is judged by go pulses on both units in the cycle after the shared completion. The second is judged by the final flag value, which matches only a data-movement-then-compute update order. A directed sequence fills the compute queue behind an unmet flag and confirms that the ninth instruction is dropped. It then confirms that exactly eight tags drain in order once a load sets the flag.

// File: rtl/dfd_pkg.sv
package dfd_pkg;
  localparam int NFLAG = 16;
  localparam int TAGW  = 8;
  localparam int NKIND = 2;  // index 0: data movement, index 1: compute

  typedef struct packed {
    logic [TAGW-1:0]  tag;
    logic [NFLAG-1:0] wset;
    logic [NFLAG-1:0] wclr;
    logic [NFLAG-1:0] sdone;
    logic [NFLAG-1:0] cdone;
  } instr_t;

  localparam int IW = $bits(instr_t);

  // all required-set flags are 1 and all required-clear flags are 0
  function automatic logic deps_met(input logic [NFLAG-1:0] f,
                                    input logic [NFLAG-1:0] ws,
                                    input logic [NFLAG-1:0] wc);
    return ((f & ws) == ws) && ((f & wc) == '0);
  endfunction

  // clear first, then set: a bit in both masks ends at 1
  function automatic logic [NFLAG-1:0] apply_done(input logic [NFLAG-1:0] f,
                                                  input logic [NFLAG-1:0] s,
                                                  input logic [NFLAG-1:0] c,
                                                  input logic en);
    return en ? ((f & ~c) | s) : f;
  endfunction
endpackage

// File: rtl/dfd_queue.sv
module dfd_queue #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= push_data;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      if (push && !pop)      count <= count + 1'b1;
      else if (!push && pop) count <= count - 1'b1;
    end
  end

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  p_no_underflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/dfd_issue_slot.sv
module dfd_issue_slot
  import dfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  instr_t           head,
  input  logic             head_vld,
  input  logic [NFLAG-1:0] flags_after,
  input  logic             done,
  output logic             pop,
  output logic             go,
  output logic [TAGW-1:0]  go_tag,
  output logic             done_vld,
  output logic [NFLAG-1:0] pend_set,
  output logic [NFLAG-1:0] pend_clr
);
  logic busy_q;
  logic free;

  assign done_vld = done && busy_q;       // stray pulses on an idle unit are dropped
  assign free     = !busy_q || done;
  assign pop      = head_vld && free && deps_met(flags_after, head.wset, head.wclr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      go       <= 1'b0;
      go_tag   <= '0;
      pend_set <= '0;
      pend_clr <= '0;
    end else begin
      go <= pop;
      if (pop) begin
        busy_q   <= 1'b1;
        go_tag   <= head.tag;
        pend_set <= head.sdone;
        pend_clr <= head.cdone;
      end else if (done_vld) begin
        busy_q <= 1'b0;
      end
    end
  end

  // back-to-back issue only when the first one completed in its go cycle
  p_one_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !done) |=> !go);
endmodule

// File: rtl/dfd_flag_unit.sv
module dfd_flag_unit
  import dfd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_vld [NKIND],
  input  logic [NFLAG-1:0] pend_set [NKIND],
  input  logic [NFLAG-1:0] pend_clr [NKIND],
  output logic [NFLAG-1:0] flags_q,
  output logic [NFLAG-1:0] flags_after
);
  logic [NFLAG-1:0] stage [NKIND+1];

  // data movement (index 0) is applied before compute (index 1)
  assign stage[0] = flags_q;
  for (genvar k = 0; k < NKIND; k++) begin : g_chain
    assign stage[k+1] = apply_done(stage[k], pend_set[k], pend_clr[k], done_vld[k]);
  end
  assign flags_after = stage[NKIND];

  always_ff @(posedge clk) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_after;
  end

  p_cmp_set_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_vld[1] |=> ((flags_q & $past(pend_set[1])) == $past(pend_set[1])));
  p_idle_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_vld[0] && !done_vld[1]) |=> (flags_q == $past(flags_q)));
endmodule

// File: rtl/depflag_dispatch.sv
module depflag_dispatch
  import dfd_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_kind,
  input  logic [TAGW-1:0]  in_tag,
  input  logic [NFLAG-1:0] in_wait_set,
  input  logic [NFLAG-1:0] in_wait_clr,
  input  logic [NFLAG-1:0] in_set_done,
  input  logic [NFLAG-1:0] in_clr_done,
  output logic             in_ready,
  output logic             dma_go,
  output logic [TAGW-1:0]  dma_go_tag,
  output logic             cmp_go,
  output logic [TAGW-1:0]  cmp_go_tag,
  input  logic             dma_done,
  input  logic             cmp_done,
  output logic [NFLAG-1:0] flags
);
  instr_t           in_word;
  instr_t           head     [NKIND];
  logic [IW-1:0]    head_raw [NKIND];
  logic             empty    [NKIND];
  logic             full     [NKIND];
  logic             push     [NKIND];
  logic             pop      [NKIND];
  logic             go       [NKIND];
  logic [TAGW-1:0]  go_tag   [NKIND];
  logic             done_in  [NKIND];
  logic             done_vld [NKIND];
  logic [NFLAG-1:0] pend_set [NKIND];
  logic [NFLAG-1:0] pend_clr [NKIND];
  logic [NFLAG-1:0] flags_after;

  assign in_word  = '{tag: in_tag, wset: in_wait_set, wclr: in_wait_clr,
                      sdone: in_set_done, cdone: in_clr_done};
  assign in_ready = !full[in_kind];
  assign done_in[0] = dma_done;
  assign done_in[1] = cmp_done;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    assign push[k] = in_valid && in_ready && (in_kind == 1'(k));
    assign head[k] = instr_t'(head_raw[k]);

    dfd_queue #(.DEPTH(DEPTH), .W(IW)) u_q (
      .clk(clk), .rst_n(rst_n), .push(push[k]), .push_data(in_word),
      .pop(pop[k]), .head(head_raw[k]), .empty(empty[k]), .full(full[k]));

    dfd_issue_slot u_slot (
      .clk(clk), .rst_n(rst_n), .head(head[k]), .head_vld(!empty[k]),
      .flags_after(flags_after), .done(done_in[k]), .pop(pop[k]),
      .go(go[k]), .go_tag(go_tag[k]), .done_vld(done_vld[k]),
      .pend_set(pend_set[k]), .pend_clr(pend_clr[k]));
  end

  dfd_flag_unit u_flags (
    .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .pend_set(pend_set),
    .pend_clr(pend_clr), .flags_q(flags), .flags_after(flags_after));

  assign dma_go     = go[0];
  assign dma_go_tag = go_tag[0];
  assign cmp_go     = go[1];
  assign cmp_go_tag = go_tag[1];

  p_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    full[1] |-> !push[1]);
endmodule

// File: tb/tb_depflag_dispatch.sv
module tb_depflag_dispatch;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_kind;
  logic [7:0]  in_tag;
  logic [15:0] in_wait_set, in_wait_clr, in_set_done, in_clr_done;
  logic        in_ready, dma_go, cmp_go, dma_done, cmp_done;
  logic [7:0]  dma_go_tag, cmp_go_tag;
  logic [15:0] flags;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  depflag_dispatch dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_tag(in_tag), .in_wait_set(in_wait_set), .in_wait_clr(in_wait_clr),
    .in_set_done(in_set_done), .in_clr_done(in_clr_done), .in_ready(in_ready),
    .dma_go(dma_go), .dma_go_tag(dma_go_tag), .cmp_go(cmp_go),
    .cmp_go_tag(cmp_go_tag), .dma_done(dma_done), .cmp_done(cmp_done),
    .flags(flags));

  typedef struct packed {
    logic v; logic k; logic [7:0] tag;
    logic [15:0] ws, wc, sd, cd;
    logic dd, cdn;
    logic edg; logic [7:0] edt;
    logic ecg; logic [7:0] ect;
    logic [15:0] ef;
  } vec_t;

  // inputs of row i are applied for one cycle; expectations hold after that edge
  localparam vec_t TBL [15] = '{
    '{1'b1,1'b1,8'h10,16'h0001,16'h0000,16'h0002,16'h0001,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0000}, // R3 compute waits flag0
    '{1'b1,1'b0,8'h20,16'h0000,16'h0000,16'h0001,16'h0000,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0000},
    '{1'b1,1'b0,8'h21,16'h0000,16'h0004,16'h0004,16'h0000,1'b0,1'b0, 1'b1,8'h20,1'b0,8'h00,16'h0000}, // R5 load bypasses
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0000},
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b1,1'b0, 1'b1,8'h21,1'b1,8'h10,16'h0001}, // R8 both issue
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0001},
    '{1'b1,1'b0,8'h22,16'h0000,16'h0001,16'h0001,16'h0000,1'b1,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0005},
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0005}, // R4 load waits clear
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b0,1'b1, 1'b1,8'h22,1'b0,8'h00,16'h0006}, // R6 compute clears
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b1,1'b1, 1'b0,8'h00,1'b0,8'h00,16'h0007}, // R11 idle compute done
    '{1'b1,1'b1,8'h11,16'h0006,16'h0000,16'h0008,16'h0000,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0007},
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b0,1'b0, 1'b0,8'h00,1'b1,8'h11,16'h0007},
    '{1'b1,1'b0,8'h23,16'h0000,16'h0000,16'h0010,16'h0008,1'b0,1'b0, 1'b0,8'h00,1'b0,8'h00,16'h0007},
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b0,1'b0, 1'b1,8'h23,1'b0,8'h00,16'h0007},
    '{1'b0,1'b0,8'h00,16'h0000,16'h0000,16'h0000,16'h0000,1'b1,1'b1, 1'b0,8'h00,1'b0,8'h00,16'h001F}  // R7 compute wins
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    in_valid = 0; in_kind = 0; in_tag = 0;
    in_wait_set = 0; in_wait_clr = 0; in_set_done = 0; in_clr_done = 0;
    dma_done = 0; cmp_done = 0;
  endtask

  task automatic push_in(input logic k, input logic [7:0] t, input logic [15:0] ws,
                         input logic [15:0] wc, input logic [15:0] sd, input logic [15:0] cd);
    in_valid = 1; in_kind = k; in_tag = t;
    in_wait_set = ws; in_wait_clr = wc; in_set_done = sd; in_clr_done = cd;
  endtask

  task automatic step();
    @(posedge clk); #1;
    idle();
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(flags == 16'h0, "R1 flags", flags, 0);
    chk(!dma_go && !cmp_go, "R1 go", {dma_go, cmp_go}, 0);
    in_kind = 1; #1 chk(in_ready, "R1 ready cmp", in_ready, 1);
    in_kind = 0; #1 chk(in_ready, "R1 ready dma", in_ready, 1);

    for (int i = 0; i < 15; i++) begin
      vec_t r = TBL[i];
      in_valid = r.v; in_kind = r.k; in_tag = r.tag;
      in_wait_set = r.ws; in_wait_clr = r.wc; in_set_done = r.sd; in_clr_done = r.cd;
      dma_done = r.dd; cmp_done = r.cdn;
      step();
      chk(dma_go == r.edg && (!r.edg || dma_go_tag == r.edt), "R2 dma issue",
          {dma_go, dma_go_tag}, {r.edg, r.edt});
      chk(cmp_go == r.ecg && (!r.ecg || cmp_go_tag == r.ect), "R3 cmp issue",
          {cmp_go, cmp_go_tag}, {r.ecg, r.ect});
      chk(flags == r.ef, "R6 flags", flags, r.ef);
    end

    // R9 one outstanding per kind, in order; R6 set wins over clear
    do_reset();
    push_in(0, 8'h30, 0, 0, 0, 0); step();
    push_in(0, 8'h31, 0, 0, 16'h0100, 16'h0100); step();
    chk(dma_go && dma_go_tag == 8'h30, "R9 first go", dma_go_tag, 8'h30);
    step();
    chk(!dma_go, "R9 held while busy", dma_go, 0);
    dma_done = 1; step();
    chk(dma_go && dma_go_tag == 8'h31, "R9 second go", dma_go_tag, 8'h31);
    dma_done = 1; step();
    chk(flags == 16'h0100, "R6 set wins", flags, 16'h0100);
    dma_done = 1; cmp_done = 1; step();
    chk(flags == 16'h0100 && !dma_go && !cmp_go, "R11 stray done", flags, 16'h0100);

    // R10 fill compute queue behind flag15
    do_reset();
    for (int i = 0; i < 8; i++) begin
      push_in(1, 8'h40 + 8'(i), 16'h8000, 0, 0, 0); step();
    end
    in_kind = 1; #1 chk(!in_ready, "R10 full ready", in_ready, 0);
    in_kind = 0; #1 chk(in_ready, "R10 other kind ready", in_ready, 1);
    push_in(1, 8'h4F, 0, 0, 0, 0); step();       // dropped
    push_in(0, 8'h50, 0, 0, 16'h8000, 0); step();
    step();
    chk(dma_go && dma_go_tag == 8'h50, "R5 load go", dma_go_tag, 8'h50);
    dma_done = 1; step();
    chk(cmp_go && cmp_go_tag == 8'h40, "R8 release", cmp_go_tag, 8'h40);
    for (int i = 1; i < 8; i++) begin
      cmp_done = 1; step();
      chk(cmp_go && cmp_go_tag == 8'h40 + 8'(i), "R2 drain order", cmp_go_tag, 8'h40 + i);
    end
    cmp_done = 1; step();
    chk(!cmp_go, "R10 dropped entry", cmp_go, 0);
    step();
    chk(!cmp_go, "R10 queue empty", cmp_go, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule